// File: doc/BRIEF.md
# Card Host Address Decoder

This block sits between the host bus of a plug-in serial card and the card's internal targets. It turns each host cycle into a select for the structure that owns the address. Two kinds of cycle are handled. Attribute-memory cycles are word-addressed on even bytes. They reach either a 256-entry card information region or one of eight configuration registers. I/O cycles are compared against one of four legacy serial port windows, each eight bytes wide, and the host picks the window with a 2-bit input.

For an I/O cycle that falls inside the chosen window, the block outputs the 3-bit register offset and a one-hot select over twelve serial controller registers. The select depends on the offset, on the read or write direction, and on a banking bit. The decoder keeps its own copy of the banking bit, taken from bit 7 of every write to the line control register.

Each request is a single-cycle strobe. The decoder accepts one in every cycle and never pushes back, so it has no ready signal. Every result is registered and appears on the cycle after its strobe, for that one cycle only.

Top module: `card_host_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every select output is low, `io_offset` is 0 and `bank_bit` is 0.
- R2: An attribute cycle with `addr[0]` = 1 selects nothing: `cis_sel`, `cfg_sel` and `attr_void_rd` all stay low.
- R3: An attribute cycle with `addr[0]` = 0 and index `addr[9:1]` in 0..255 raises `cis_sel` and drives `cis_index` with the index.
- R4: An attribute cycle with `addr[0]` = 0 and index 256..263 raises only bit (index − 256) of `cfg_sel`.
- R5: An attribute cycle with `addr[0]` = 0 and index 264..511 selects nothing. On a read (`wr` = 0) it raises `attr_void_rd`, telling the data path to return zero. On a write, `attr_void_rd` stays low.
- R6: `base_sel` picks the I/O window base: 0 → 0x3F8, 1 → 0x2F8, 2 → 0x3E8, 3 → 0x2E8. An I/O cycle raises `io_hit` only when `addr` lies within base..base+7. Outside the window, `io_hit` and all `reg_sel` bits stay low.
- R7: On an I/O hit, `io_offset` equals `addr[2:0]`.
- R8: The `reg_sel` bit positions are: 0 receive buffer, 1 transmit holding, 2 divisor low, 3 interrupt enable, 4 divisor high, 5 interrupt identification, 6 FIFO control, 7 line control, 8 modem control, 9 line status, 10 modem status, 11 scratch. At offset 0 with the banking bit clear, a read selects bit 0 and a write selects bit 1. With the banking bit set, offset 0 selects bit 2 in either direction.
- R9: At offset 1, the interrupt enable register (bit 3) is selected when the banking bit is clear, and divisor high (bit 4) when it is set. Direction does not matter.
- R10: At offset 2, a read selects bit 5 and a write selects bit 6, whatever the banking bit.
- R11: Offsets 3, 4, 5, 6 and 7 select bits 7, 8, 9, 10 and 11 respectively, whatever the direction and the banking bit.
- R12: An I/O write that hits offset 3 of the active window loads `bank_wbit` into the banking bit. The new value shows on `bank_bit` one cycle later and governs every access strobed from the next cycle on. No other cycle changes the banking bit.
- R13: Each result appears on the cycle after its strobe and lasts one cycle. In a cycle with no strobe, every select output is low on the next cycle.
- R14: When `attr_req` and `io_req` are asserted together, only the attribute decode takes effect. The I/O decode, including the banking-bit update, is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 2 | Chooses the active I/O window base |
| attr_req | input | 1 | Single-cycle attribute-memory strobe |
| io_req | input | 1 | Single-cycle I/O strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Host byte address |
| bank_wbit | input | 1 | Bit 7 of the host write data |
| cis_sel | output | 1 | Card information region selected |
| cis_index | output | 8 | Entry index in the information region |
| cfg_sel | output | 8 | One-hot configuration register select |
| attr_void_rd | output | 1 | Attribute read to an unused index; return zero |
| io_hit | output | 1 | I/O cycle inside the active window |
| io_offset | output | 3 | Register offset within the window |
| reg_sel | output | 12 | One-hot serial controller register select |
| bank_bit | output | 1 | Current banking bit |

## Verification
Every decode result is due exactly one clock edge after the edge that samples its strobe. The banking bit shows on `bank_bit` after that same edge, and a strobe driven in the following cycle is the first to be decoded under the new value. The bench changes inputs on the falling edge and reads outputs 1 ns after the next rising edge, so each check lands in the one cycle its result is valid. Between scenarios an idle cycle confirms that the selects have dropped.

// File: rtl/card_dec_pkg.sv
package card_dec_pkg;
  // Host byte address width covering the legacy I/O page and attribute space.
  localparam int ADDR_W = 10;
  // Offset bits inside one I/O window.
  localparam int OFF_W = 3;
  // Number of serial controller register targets.
  localparam int NUM_TGT = 12;

  // Positions in the one-hot register select vector.
  localparam int SEL_RXBUF = 0;
  localparam int SEL_TXHOLD = 1;
  localparam int SEL_DIVLO = 2;
  localparam int SEL_INTEN = 3;
  localparam int SEL_DIVHI = 4;
  localparam int SEL_INTID = 5;
  localparam int SEL_FIFOC = 6;
  localparam int SEL_LINEC = 7;
  localparam int SEL_MODEMC = 8;
  localparam int SEL_LINES = 9;
  localparam int SEL_MODEMS = 10;
  localparam int SEL_SCRATCH = 11;

  // Window page number (address divided by eight) for each base choice.
  function automatic logic [ADDR_W-OFF_W-1:0] io_page(input logic [1:0] choice);
    logic [ADDR_W-1:0] base;
    case (choice)
      2'd0:    base = 10'h3F8;
      2'd1:    base = 10'h2F8;
      2'd2:    base = 10'h3E8;
      default: base = 10'h2E8;
    endcase
    return base[ADDR_W-1:OFF_W];
  endfunction
endpackage

// File: rtl/card_attr_decode.sv
module card_attr_decode
  import card_dec_pkg::*;
#(
  parameter int CIS_ENTRIES = 256,
  parameter int CFG_REGS = 8,
  localparam int IDX_W = ADDR_W - 1,
  localparam int CIS_W = $clog2(CIS_ENTRIES)
) (
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              cis_hit,
  output logic [CIS_W-1:0]  cis_idx,
  output logic [CFG_REGS-1:0] cfg_hit,
  output logic              void_rd
);
  localparam logic [IDX_W-1:0] CIS_END = IDX_W'(CIS_ENTRIES);
  localparam logic [IDX_W-1:0] CFG_END = IDX_W'(CIS_ENTRIES + CFG_REGS);

  logic [IDX_W-1:0] word_idx;
  logic             even_ok;

  assign word_idx = addr[ADDR_W-1:1];
  assign even_ok  = req && !addr[0];

  assign cis_hit = even_ok && (word_idx < CIS_END);
  assign cis_idx = word_idx[CIS_W-1:0];

  for (genvar g = 0; g < CFG_REGS; g++) begin : g_cfg
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(CIS_ENTRIES + g);
    assign cfg_hit[g] = even_ok && (word_idx == SLOT);
  end

  assign void_rd = even_ok && !wr && (word_idx >= CFG_END);
endmodule

// File: rtl/card_io_window.sv
module card_io_window
  import card_dec_pkg::*;
(
  input  logic              req,
  input  logic [1:0]        base_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  offset
);
  logic [ADDR_W-OFF_W-1:0] page;

  assign page   = io_page(base_sel);
  assign hit    = req && (addr[ADDR_W-1:OFF_W] == page);
  assign offset = addr[OFF_W-1:0];
endmodule

// File: rtl/card_reg_select.sv
module card_reg_select
  import card_dec_pkg::*;
(
  input  logic               hit,
  input  logic               wr,
  input  logic [OFF_W-1:0]   offset,
  input  logic               bank,
  output logic [NUM_TGT-1:0] sel
);
  always_comb begin
    sel = '0;
    if (hit) begin
      case (offset)
        3'd0: begin
          if (bank)    sel[SEL_DIVLO]  = 1'b1;
          else if (wr) sel[SEL_TXHOLD] = 1'b1;
          else         sel[SEL_RXBUF]  = 1'b1;
        end
        3'd1: begin
          if (bank) sel[SEL_DIVHI] = 1'b1;
          else      sel[SEL_INTEN] = 1'b1;
        end
        3'd2: begin
          if (wr) sel[SEL_FIFOC] = 1'b1;
          else    sel[SEL_INTID] = 1'b1;
        end
        3'd3:    sel[SEL_LINEC]   = 1'b1;
        3'd4:    sel[SEL_MODEMC]  = 1'b1;
        3'd5:    sel[SEL_LINES]   = 1'b1;
        3'd6:    sel[SEL_MODEMS]  = 1'b1;
        default: sel[SEL_SCRATCH] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/card_bank_track.sv
module card_bank_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic wbit,
  output logic bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= 1'b0;
    else if (load) bank <= wbit;
  end

  assert_bank_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bank == $past(wbit)));

  assert_bank_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));
endmodule

// File: rtl/card_host_decoder.sv
module card_host_decoder
  import card_dec_pkg::*;
#(
  parameter int CIS_ENTRIES = 256,
  parameter int CFG_REGS = 8,
  localparam int CIS_W = $clog2(CIS_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         base_sel,
  input  logic               attr_req,
  input  logic               io_req,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               bank_wbit,
  output logic               cis_sel,
  output logic [CIS_W-1:0]   cis_index,
  output logic [CFG_REGS-1:0] cfg_sel,
  output logic               attr_void_rd,
  output logic               io_hit,
  output logic [OFF_W-1:0]   io_offset,
  output logic [NUM_TGT-1:0] reg_sel,
  output logic               bank_bit
);
  localparam logic [OFF_W-1:0] LCR_OFF = OFF_W'(3);

  // Attribute cycles take precedence when both strobes arrive together.
  logic io_go;
  assign io_go = io_req && !attr_req;

  logic               a_cis;
  logic [CIS_W-1:0]   a_idx;
  logic [CFG_REGS-1:0] a_cfg;
  logic               a_void;

  card_attr_decode #(
    .CIS_ENTRIES(CIS_ENTRIES),
    .CFG_REGS   (CFG_REGS)
  ) u_attr (
    .req    (attr_req),
    .wr     (wr),
    .addr   (addr),
    .cis_hit(a_cis),
    .cis_idx(a_idx),
    .cfg_hit(a_cfg),
    .void_rd(a_void)
  );

  logic             w_hit;
  logic [OFF_W-1:0] w_off;

  card_io_window u_win (
    .req     (io_go),
    .base_sel(base_sel),
    .addr    (addr),
    .hit     (w_hit),
    .offset  (w_off)
  );

  logic bank_now;
  logic lcr_write;
  assign lcr_write = w_hit && wr && (w_off == LCR_OFF);

  card_bank_track u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .load (lcr_write),
    .wbit (bank_wbit),
    .bank (bank_now)
  );

  logic [NUM_TGT-1:0] s_sel;

  card_reg_select u_sel (
    .hit   (w_hit),
    .wr    (wr),
    .offset(w_off),
    .bank  (bank_now),
    .sel   (s_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cis_sel      <= 1'b0;
      cis_index    <= '0;
      cfg_sel      <= '0;
      attr_void_rd <= 1'b0;
      io_hit       <= 1'b0;
      io_offset    <= '0;
      reg_sel      <= '0;
    end else begin
      cis_sel      <= a_cis;
      cis_index    <= a_cis ? a_idx : '0;
      cfg_sel      <= a_cfg;
      attr_void_rd <= a_void;
      io_hit       <= w_hit;
      io_offset    <= w_hit ? w_off : '0;
      reg_sel      <= s_sel;
    end
  end

  assign bank_bit = bank_now;

  assert_cfg_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_sel));

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel));

  assert_sel_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel != '0) |-> io_hit);

  assert_hit_has_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> ($countones(reg_sel) == 1));

  assert_idle_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!attr_req && !io_req) |=> (!cis_sel && !io_hit && cfg_sel == '0 && !attr_void_rd));

  assert_attr_wins_R14: assert property (@(posedge clk) disable iff (!rst_n)
    attr_req |=> !io_hit);
endmodule

// File: tb/card_host_decoder_bench.sv
`timescale 1ns/1ps
module card_host_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  base_sel = 2'd0;
  logic        attr_req = 1'b0;
  logic        io_req = 1'b0;
  logic        wr = 1'b0;
  logic [9:0]  addr = '0;
  logic        bank_wbit = 1'b0;
  logic        cis_sel;
  logic [7:0]  cis_index;
  logic [7:0]  cfg_sel;
  logic        attr_void_rd;
  logic        io_hit;
  logic [2:0]  io_offset;
  logic [11:0] reg_sel;
  logic        bank_bit;

  int vectors = 0;
  int miscompares = 0;
  bit reported = 0;
  bit model_bank = 0;

  always #5 clk = ~clk;

  card_host_decoder u_card_host_decoder (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .attr_req(attr_req),
    .io_req(io_req), .wr(wr), .addr(addr), .bank_wbit(bank_wbit),
    .cis_sel(cis_sel), .cis_index(cis_index), .cfg_sel(cfg_sel),
    .attr_void_rd(attr_void_rd), .io_hit(io_hit), .io_offset(io_offset),
    .reg_sel(reg_sel), .bank_bit(bank_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  // Drive one strobe cycle at the falling edge, sample 1 ns after the next rising edge.
  task automatic cyc(input logic a, input logic i, input logic w, input logic [9:0] ad,
                     input logic wb);
    @(negedge clk);
    attr_req = a; io_req = i; wr = w; addr = ad; bank_wbit = wb;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, 10'h000, 1'b0);
  endtask

  function automatic logic [11:0] exp_sel(input int off, input bit w, input bit bk);
    case (off)
      0: return bk ? 12'h004 : (w ? 12'h002 : 12'h001);
      1: return bk ? 12'h010 : 12'h008;
      2: return w ? 12'h040 : 12'h020;
      default: return 12'h001 << (off + 4);
    endcase
  endfunction

  function automatic logic [9:0] base_of(input int s);
    case (s)
      0: return 10'h3F8;
      1: return 10'h2F8;
      2: return 10'h3E8;
      default: return 10'h2E8;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 cis_sel in reset", cis_sel, 0);
    chk("R1 reg_sel in reset", reg_sel, 0);
    chk("R1 bank_bit in reset", bank_bit, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 cfg_sel after reset", cfg_sel, 0);
    chk("R1 io_offset after reset", io_offset, 0);
    chk("R1 io_hit after reset", io_hit, 0);
  endtask

  task automatic t_attr_cis();
    for (int k = 0; k < 256; k += 85) begin
      cyc(1'b1, 1'b0, 1'b0, 10'((k << 1)), 1'b0);
      chk("R3 cis_sel", cis_sel, 1);
      chk("R3 cis_index", cis_index, k);
      chk("R3 cfg_sel quiet", cfg_sel, 0);
    end
    idle();
    chk("R13 cis_sel drops", cis_sel, 0);
  endtask

  task automatic t_attr_cfg();
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 1'b0, k[0], 10'((256 + k) << 1), 1'b0);
      chk("R4 cfg_sel", cfg_sel, 32'h1 << k);
      chk("R4 cis_sel quiet", cis_sel, 0);
    end
  endtask

  task automatic t_attr_odd();
    cyc(1'b1, 1'b0, 1'b0, 10'h003, 1'b0);
    chk("R2 odd cis", cis_sel, 0);
    cyc(1'b1, 1'b0, 1'b0, 10'h201, 1'b0);
    chk("R2 odd cfg", cfg_sel, 0);
    cyc(1'b1, 1'b0, 1'b0, 10'h3FF, 1'b0);
    chk("R2 odd void", attr_void_rd, 0);
  endtask

  task automatic t_attr_void();
    cyc(1'b1, 1'b0, 1'b0, 10'(264 << 1), 1'b0);
    chk("R5 void read low edge", attr_void_rd, 1);
    chk("R5 no cfg", cfg_sel, 0);
    cyc(1'b1, 1'b0, 1'b0, 10'(511 << 1), 1'b0);
    chk("R5 void read top", attr_void_rd, 1);
    chk("R5 no cis", cis_sel, 0);
    cyc(1'b1, 1'b0, 1'b1, 10'(300 << 1), 1'b0);
    chk("R5 void write", attr_void_rd, 0);
    cyc(1'b1, 1'b0, 1'b0, 10'(263 << 1), 1'b0);
    chk("R5 last cfg not void", attr_void_rd, 0);
  endtask

  task automatic t_io_bases();
    for (int s = 0; s < 4; s++) begin
      base_sel = 2'(s);
      for (int b = 0; b < 4; b++) begin
        cyc(1'b0, 1'b1, 1'b0, base_of(b) + 10'd5, 1'b0);
        chk("R6 window match", io_hit, (s == b) ? 1 : 0);
        chk("R6 select gated", reg_sel, (s == b) ? 32'h200 : 0);
      end
      cyc(1'b0, 1'b1, 1'b0, base_of(s) - 10'd1, 1'b0);
      chk("R6 below window", io_hit, 0);
      cyc(1'b0, 1'b1, 1'b0, base_of(s) + 10'd8, 1'b0);
      chk("R6 above window", io_hit, 0);
    end
    base_sel = 2'd0;
  endtask

  task automatic t_offsets(input bit bk);
    for (int o = 0; o < 8; o++) begin
      for (int w = 0; w < 2; w++) begin
        if (!(o == 3 && w == 1)) begin
          cyc(1'b0, 1'b1, w[0], base_of(int'(base_sel)) + 10'(o), 1'b0);
          chk("R7 offset", io_offset, o);
          if (o == 0)      chk("R8 offset0 select", reg_sel, exp_sel(o, w[0], bk));
          else if (o == 1) chk("R9 offset1 select", reg_sel, exp_sel(o, w[0], bk));
          else if (o == 2) chk("R10 offset2 select", reg_sel, exp_sel(o, w[0], bk));
          else             chk("R11 fixed select", reg_sel, exp_sel(o, w[0], bk));
        end
      end
    end
  endtask

  task automatic lcr_write(input bit v);
    cyc(1'b0, 1'b1, 1'b1, base_of(int'(base_sel)) + 10'd3, v);
    model_bank = v;
    chk("R11 lcr write select", reg_sel, 32'h080);
    chk("R12 bank visible", bank_bit, v);
  endtask

  task automatic t_bank();
    base_sel = 2'd2;
    t_offsets(0);
    lcr_write(1);
    t_offsets(1);
    // Write to a line control offset outside the active window: no bank change.
    cyc(1'b0, 1'b1, 1'b1, 10'h3FB, 1'b0);
    chk("R12 foreign window ignored", bank_bit, 1);
    cyc(1'b0, 1'b1, 1'b0, 10'h3E8, 1'b0);
    chk("R12 still banked", reg_sel, 32'h004);
    // A read of the line control offset does not reload.
    cyc(1'b0, 1'b1, 1'b0, 10'h3EB, 1'b0);
    chk("R12 lcr read ignored", bank_bit, 1);
    lcr_write(0);
    cyc(1'b0, 1'b1, 1'b0, 10'h3E8, 1'b0);
    chk("R12 unbanked again", reg_sel, 32'h001);
    base_sel = 2'd0;
  endtask

  task automatic t_priority();
    cyc(1'b1, 1'b1, 1'b0, 10'h3F8, 1'b0);
    chk("R14 io suppressed", io_hit, 0);
    chk("R14 no reg select", reg_sel, 0);
    chk("R14 attr decoded", attr_void_rd, 1);
    cyc(1'b1, 1'b1, 1'b1, 10'h3FB, 1'b1);
    idle();
    chk("R14 bank untouched", bank_bit, model_bank);
    chk("R13 idle io_hit", io_hit, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_attr_cis();
    t_attr_cfg();
    t_attr_odd();
    t_attr_void();
    idle();
    t_io_bases();
    t_bank();
    t_priority();
    idle();
    summary();
    $finish;
  end
endmodule